// File: doc/BRIEF.md
# Anti-Rollback Counter with Single-Use Flag

This block keeps a 64-bit monotonic counter that gates encrypted key transfers. Software proposes a new counter value through a write port. The counter moves only when the proposed value is exactly one above the value it holds. A value that is stale, repeated or far ahead is refused, so an old counter value can never be put back in place.

The counter is paired with a single usage flag. The logic that loads key registers must ask permission before every write, using a request/grant port. A request is granted only while the current counter value is still unused. Granting the request marks the value as used. Any further request is refused until the counter has been advanced again. The non-volatile storage is modelled as ordinary registers that take a preset value on reset. The flag comes out of reset set, so the counter must be advanced once before the first key transfer.

Every request is answered with a one-cycle pulse in the cycle after it is presented. When a counter write and a key request arrive together, the counter write is resolved first.

Top module: `rbk_guard`

## Requirements
- R1: After reset, `ctr_value` equals the parameter `RESET_VALUE` (default 0), and all four response pulses are low.
- R2: A counter write whose data equals the current value plus one is accepted. `ctr_value` takes the new value and `ctr_ok` is high for one cycle, both visible at the first clock edge after the write is presented.
- R3: A counter write with any other data is rejected. `ctr_value` keeps its value and `ctr_err` is high for one cycle after the write.
- R4: When `ctr_value` is all ones, every counter write is rejected, including a write of zero. The counter saturates and never wraps.
- R5: A key request while the usage flag is clear gets `key_grant` for one cycle, and the flag becomes set.
- R6: A key request while the usage flag is set gets `key_deny` for one cycle, and the flag stays set.
- R7: An accepted counter write clears the usage flag. A rejected counter write leaves the flag unchanged.
- R8: When a counter write and a key request are presented in the same cycle, the counter write is resolved first. An accepted write followed in the same cycle by a request therefore yields both `ctr_ok` and `key_grant`.
- R9: Reset sets the usage flag, so the first key request after reset is denied.
- R10: Responses are one-cycle pulses and appear only for a request of their kind. `ctr_ok` and `ctr_err` are never high together, and neither are `key_grant` and `key_deny`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctr_wr_en | input | 1 | Counter write strobe, one cycle per attempt |
| ctr_wr_data | input | 64 | Proposed new counter value |
| key_req | input | 1 | Key-register write permission request, one cycle per attempt |
| ctr_value | output | 64 | Current counter value |
| ctr_ok | output | 1 | Pulse: counter write accepted |
| ctr_err | output | 1 | Pulse: counter write rejected |
| key_grant | output | 1 | Pulse: key write permitted |
| key_deny | output | 1 | Pulse: key write refused |

## Verification
The usage flag has no port of its own, so a wrong flag state shows up only at the next key request. It appears there, one cycle later, as a grant where a deny was due, or the other way round. For this reason the bench places requests directly after every kind of counter event: accepted, rejected, simultaneous with a request, and reset. A wrong counter state or a faulty successor comparison shows in `ctr_value` and in the ok/err pulse at the first edge after the write. The saturation point is reached by presetting the counter close to all ones.

// File: rtl/rbk_pkg.sv
package rbk_pkg;
  localparam int unsigned CTR_BYTES = 8;
  localparam int unsigned CTR_W     = CTR_BYTES * 8;

  typedef struct packed {
    logic ok;
    logic err;
  } rbk_ack_t;
endpackage

// File: rtl/rbk_succ_match.sv
module rbk_succ_match #(
  parameter int unsigned W = 64
) (
  input  logic [W-1:0] cur,
  input  logic [W-1:0] cand,
  output logic         match
);
  localparam int unsigned WX = W + 1;

  logic [WX-1:0] succ;
  logic [WX-1:0] cand_x;

  // The extra top bit makes the successor of all-ones unreachable by any W-bit candidate.
  always_comb begin
    succ   = {1'b0, cur} + {{(WX-1){1'b0}}, 1'b1};
    cand_x = {1'b0, cand};
    match  = (succ == cand_x);
  end
endmodule

// File: rtl/rbk_ctr_store.sv
module rbk_ctr_store
  import rbk_pkg::*;
#(
  parameter int unsigned     W           = 64,
  parameter logic [W-1:0]    RESET_VALUE = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] value,
  output logic         accept,
  output rbk_ack_t     ack
);
  logic [W-1:0] value_q;
  logic         is_succ;

  rbk_succ_match #(.W(W)) u_succ (
    .cur   (value_q),
    .cand  (wr_data),
    .match (is_succ)
  );

  always_comb accept = wr_en & is_succ;

  always_ff @(posedge clk) begin
    if (rst) begin
      value_q <= RESET_VALUE;
      ack     <= '0;
    end else begin
      if (accept) value_q <= wr_data;
      ack.ok  <= accept;
      ack.err <= wr_en & ~is_succ;
    end
  end

  assign value = value_q;
endmodule

// File: rtl/rbk_use_flag.sv
module rbk_use_flag (
  input  logic clk,
  input  logic rst,
  input  logic ctr_accept,
  input  logic key_req,
  output logic grant,
  output logic deny
);
  logic used_q;
  logic used_eff;

  // Counter update is resolved before a request in the same cycle.
  always_comb used_eff = ctr_accept ? 1'b0 : used_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      used_q <= 1'b1;
      grant  <= 1'b0;
      deny   <= 1'b0;
    end else begin
      grant  <= key_req & ~used_eff;
      deny   <= key_req & used_eff;
      used_q <= key_req ? 1'b1 : used_eff;
    end
  end
endmodule

// File: rtl/rbk_guard.sv
module rbk_guard
  import rbk_pkg::*;
#(
  parameter int unsigned         CTR_W       = rbk_pkg::CTR_W,
  parameter logic [CTR_W-1:0]    RESET_VALUE = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctr_wr_en,
  input  logic [CTR_W-1:0] ctr_wr_data,
  input  logic             key_req,
  output logic [CTR_W-1:0] ctr_value,
  output logic             ctr_ok,
  output logic             ctr_err,
  output logic             key_grant,
  output logic             key_deny
);
  logic     accept;
  rbk_ack_t ack;

  rbk_ctr_store #(.W(CTR_W), .RESET_VALUE(RESET_VALUE)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (ctr_wr_en),
    .wr_data (ctr_wr_data),
    .value   (ctr_value),
    .accept  (accept),
    .ack     (ack)
  );

  rbk_use_flag u_flag (
    .clk        (clk),
    .rst        (rst),
    .ctr_accept (accept),
    .key_req    (key_req),
    .grant      (key_grant),
    .deny       (key_deny)
  );

  assign ctr_ok  = ack.ok;
  assign ctr_err = ack.err;
endmodule

// File: rtl/rbk_guard_chk.sv
module rbk_guard_chk #(
  parameter int unsigned CTR_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             ctr_wr_en,
  input logic             key_req,
  input logic [CTR_W-1:0] ctr_value,
  input logic             ctr_ok,
  input logic             ctr_err,
  input logic             key_grant,
  input logic             key_deny
);
  // Port-level shadow of the usage state: set by a grant, cleared by an accept.
  logic seen_used;
  always_ff @(posedge clk) begin
    if (rst)            seen_used <= 1'b1;
    else if (key_grant) seen_used <= 1'b1;
    else if (ctr_ok)    seen_used <= 1'b0;
  end

  AST_OK_ERR_EXCL:    assert property (@(posedge clk) disable iff (rst) !(ctr_ok && ctr_err)); // R10
  AST_GNT_DNY_EXCL:   assert property (@(posedge clk) disable iff (rst) !(key_grant && key_deny)); // R10
  AST_CTR_RESP_CAUSE: assert property (@(posedge clk) disable iff (rst) (ctr_ok || ctr_err) |-> $past(ctr_wr_en)); // R10
  AST_KEY_RESP_CAUSE: assert property (@(posedge clk) disable iff (rst) (key_grant || key_deny) |-> $past(key_req)); // R10
  AST_STEP_ONE:       assert property (@(posedge clk) disable iff (rst) ctr_ok |-> (ctr_value == $past(ctr_value) + 1'b1)); // R2
  AST_REJECT_HOLD:    assert property (@(posedge clk) disable iff (rst) ctr_err |-> $stable(ctr_value)); // R3
  AST_NO_SILENT_MOVE: assert property (@(posedge clk) disable iff (rst) !ctr_ok |-> $stable(ctr_value)); // R3
  AST_NO_WRAP:        assert property (@(posedge clk) disable iff (rst) ctr_ok |-> (ctr_value != '0)); // R4
  AST_GRANT_FRESH:    assert property (@(posedge clk) disable iff (rst) key_grant |-> (!seen_used || ctr_ok)); // R5
  AST_DENY_STALE:     assert property (@(posedge clk) disable iff (rst) key_deny |-> (seen_used && !ctr_ok)); // R6
endmodule

bind rbk_guard rbk_guard_chk #(.CTR_W(CTR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ctr_wr_en (ctr_wr_en),
  .key_req   (key_req),
  .ctr_value (ctr_value),
  .ctr_ok    (ctr_ok),
  .ctr_err   (ctr_err),
  .key_grant (key_grant),
  .key_deny  (key_deny)
);

// File: tb/test_rbk_guard.sv
`timescale 1ns/1ps
module test_rbk_guard;
  localparam int unsigned W  = 64;
  localparam logic [W-1:0] HI_PRESET = 64'hFFFF_FFFF_FFFF_FFFE;
  localparam logic [W-1:0] ONES      = 64'hFFFF_FFFF_FFFF_FFFF;

  typedef struct packed {
    logic         wr;
    logic [W-1:0] d;
    logic         rq;
    logic         ok;
    logic         err;
    logic         gr;
    logic         dn;
    logic [W-1:0] v;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 64'd0}, // R9 first request denied
    '{1'b1, 64'd1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 64'd1}, // R2 step to 1
    '{1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 64'd1}, // R5 grant
    '{1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 64'd1}, // R6 deny reuse
    '{1'b1, 64'd5, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 64'd1}, // R3 jump ahead
    '{1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 64'd1}, // R7 reject keeps flag
    '{1'b1, 64'd2, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 64'd2}, // R8 same cycle
    '{1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 64'd2}, // R6
    '{1'b1, 64'd3, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 64'd3}, // R7 accept clears
    '{1'b0, 64'd0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 64'd3}, // R10 idle
    '{1'b0, 64'd0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 64'd3}, // R5
    '{1'b1, 64'd3, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 64'd3}, // R3 repeat value
    '{1'b1, 64'd2, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 64'd3}  // R3 rollback
  };

  logic clk = 1'b0;
  logic rst;
  logic ctr_wr_en, key_req;
  logic [W-1:0] ctr_wr_data;
  logic [W-1:0] ctr_value, hi_value;
  logic ctr_ok, ctr_err, key_grant, key_deny;
  logic hi_ok, hi_err, hi_grant, hi_deny;

  int n_vec = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  rbk_guard #(.CTR_W(W)) i_rbk_guard (
    .clk(clk), .rst(rst), .ctr_wr_en(ctr_wr_en), .ctr_wr_data(ctr_wr_data),
    .key_req(key_req), .ctr_value(ctr_value), .ctr_ok(ctr_ok), .ctr_err(ctr_err),
    .key_grant(key_grant), .key_deny(key_deny)
  );

  rbk_guard #(.CTR_W(W), .RESET_VALUE(HI_PRESET)) i_rbk_guard_hi (
    .clk(clk), .rst(rst), .ctr_wr_en(ctr_wr_en), .ctr_wr_data(ctr_wr_data),
    .key_req(key_req), .ctr_value(hi_value), .ctr_ok(hi_ok), .ctr_err(hi_err),
    .key_grant(hi_grant), .key_deny(hi_deny)
  );

  task automatic chk(input string tag, input string what, input logic [W-1:0] act, input logic [W-1:0] exp);
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic chk_main(input string tag, input logic ok, input logic err, input logic gr,
                          input logic dn, input logic [W-1:0] v);
    n_vec++;
    chk(tag, "ctr_value", ctr_value, v);
    chk(tag, "ctr_ok", {63'd0, ctr_ok}, {63'd0, ok});
    chk(tag, "ctr_err", {63'd0, ctr_err}, {63'd0, err});
    chk(tag, "key_grant", {63'd0, key_grant}, {63'd0, gr});
    chk(tag, "key_deny", {63'd0, key_deny}, {63'd0, dn});
  endtask

  task automatic chk_hi(input string tag, input logic ok, input logic err, input logic gr,
                        input logic dn, input logic [W-1:0] v);
    n_vec++;
    chk(tag, "hi ctr_value", hi_value, v);
    chk(tag, "hi ctr_ok", {63'd0, hi_ok}, {63'd0, ok});
    chk(tag, "hi ctr_err", {63'd0, hi_err}, {63'd0, err});
    chk(tag, "hi key_grant", {63'd0, hi_grant}, {63'd0, gr});
    chk(tag, "hi key_deny", {63'd0, hi_deny}, {63'd0, dn});
  endtask

  // Present inputs at a falling edge; outputs are sampled at the next falling edge.
  task automatic apply(input logic wr, input logic [W-1:0] d, input logic rq);
    ctr_wr_en = wr; ctr_wr_data = d; key_req = rq;
    @(negedge clk);
    ctr_wr_en = 1'b0; ctr_wr_data = '0; key_req = 1'b0;
  endtask

  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    rst = 1'b1; ctr_wr_en = 1'b0; ctr_wr_data = '0; key_req = 1'b0;
    @(negedge clk);
    do_reset();
    chk_main("R1", 1'b0, 1'b0, 1'b0, 1'b0, 64'd0);
    chk_hi("R1", 1'b0, 1'b0, 1'b0, 1'b0, HI_PRESET);

    for (int i = 0; i < NV; i++) begin
      apply(VECS[i].wr, VECS[i].d, VECS[i].rq);
      chk_main($sformatf("vector %0d", i), VECS[i].ok, VECS[i].err, VECS[i].gr, VECS[i].dn, VECS[i].v);
    end

    // Accept 4 (clears flag), then reset: flag must be set again, counter back to preset.
    apply(1'b1, 64'd4, 1'b0);
    chk_main("R2", 1'b1, 1'b0, 1'b0, 1'b0, 64'd4);
    do_reset();
    chk_main("R1", 1'b0, 1'b0, 1'b0, 1'b0, 64'd0);
    apply(1'b0, 64'd0, 1'b1);
    chk_main("R9", 1'b0, 1'b0, 1'b0, 1'b1, 64'd0);
    apply(1'b1, 64'd1, 1'b1);
    chk_main("R8", 1'b1, 1'b0, 1'b1, 1'b0, 64'd1);

    // Saturation on the preset instance.
    do_reset();
    apply(1'b1, ONES, 1'b0);
    chk_hi("R2", 1'b1, 1'b0, 1'b0, 1'b0, ONES);
    apply(1'b0, 64'd0, 1'b1);
    chk_hi("R5", 1'b0, 1'b0, 1'b1, 1'b0, ONES);
    apply(1'b1, 64'd0, 1'b0);
    chk_hi("R4", 1'b0, 1'b1, 1'b0, 1'b0, ONES);
    apply(1'b1, ONES, 1'b1);
    chk_hi("R4", 1'b0, 1'b1, 1'b0, 1'b1, ONES);
    apply(1'b0, 64'd0, 1'b0);
    chk_hi("R10", 1'b0, 1'b0, 1'b0, 1'b0, ONES);

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #100000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule